// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a three-step digital lock. A keypad front end (outside this block) presents one 4-bit value at a time on `key_val` and pulses `key_new` for one cycle when that value is valid. Inside, three registers hold the secret combination. A selector picks the stored digit for the current step, and a combinational equality test compares it against the entered value. A small controller advances one step per matching entry. It stops at an error state on the first wrong entry, so it never collects all three values before deciding.

The combination is written while the lock is held in reset. With `cfg_we` high, the registers take `cfg_code`. With `cfg_we` low, they take the built-in default of 3, then 4, then 2. Outside reset the stored digits cannot change. The `unlock` output rises only after the full combination has been entered in order. Both the open and the error outcome persist until the next reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the controller returns to step 0 with the first stored digit selected, and `unlock` reads 0 from the following cycle on.
- R2: In any step, a cycle with `key_new` low changes neither the step nor the digit selection, and `unlock` stays 0.
- R3: With `key_new` high in step k (k = 0 or 1), an entry equal to stored digit k moves the controller to step k+1, which compares against stored digit k+1.
- R4: With `key_new` high in a waiting step, an entry that differs from the selected stored digit sends the controller to the error state; `unlock` stays 0.
- R5: With `key_new` high in step 2, an entry equal to stored digit 2 moves the controller to the open state. `unlock` is 1 from the cycle after that edge, and it is 1 in no other state.
- R6: The open state persists until reset, whatever values are strobed in with `key_new`.
- R7: The error state persists until reset. Strobed entries, including the full correct combination, leave `unlock` at 0.
- R8: At a rising edge with `rst` high, stored digit i takes `cfg_code[4*i+3:4*i]` when `cfg_we` is 1, and the default (digit 0 = 3, digit 1 = 4, digit 2 = 2) when `cfg_we` is 0. When `rst` is low, `cfg_we` has no effect.
- R9: The comparison is combinational. The entry is judged in the same cycle that `key_new` is high, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also the window in which the combination is loaded |
| key_val | input | 4 | Entered value |
| key_new | input | 1 | One-cycle strobe marking `key_val` as a fresh entry |
| cfg_we | input | 1 | Load enable for the combination, honoured only during reset |
| cfg_code | input | 12 | Combination to load; digit i in bits 4*i+3 to 4*i, digit 0 entered first |
| unlock | output | 1 | 1 only in the open state |

## Verification
The bench sweeps every one of the 16 values through each of the three positions, for the default combination, a loaded one with distinct digits and a loaded one with repeated digits, and inserts idle cycles between entries.

Each class of bug shows up differently:
- A selector that picks the wrong digit opens on the wrong value.
- A controller that restarts on a mismatch instead of locking into error opens when the correct combination is re-entered after a wrong one.
- A controller that advances without the strobe moves on during the idle gaps.

Further directed sequences strobe values into the open and error states, reset out of both, and pulse `cfg_we` outside reset to confirm that the stored combination survives.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_ERR  = 2'd1,
        PH_OPEN = 2'd2
    } lock_phase_e;

endpackage

// File: rtl/lock_code_store.sv
module lock_code_store #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 3,
    parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEFAULT_CODE = 12'h243,
    localparam int SEL_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] cfg_code,
    input  logic [SEL_W-1:0]              sel,
    input  logic [DIGIT_W-1:0]            key_val,
    output logic                          match
);

    typedef struct packed {
        logic [NUM_DIGITS-1:0][DIGIT_W-1:0] code;
    } store_t;

    store_t st_d, st_q;
    logic [DIGIT_W-1:0] picked;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < NUM_DIGITS; i++) begin
                st_d.code[i] = cfg_we ? cfg_code[i*DIGIT_W +: DIGIT_W]
                                      : DEFAULT_CODE[i*DIGIT_W +: DIGIT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // digit selector driven by the controller step
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (sel == SEL_W'(i)) picked = st_q.code[i];
        end
    end

    assign match = (picked == key_val);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(st_q.code));

endmodule

// File: rtl/lock_sequencer.sv
module lock_sequencer
    import lock_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    localparam int SEL_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_new,
    input  logic             match,
    output logic [SEL_W-1:0] sel,
    output logic             unlock
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_DIGITS - 1);

    typedef struct packed {
        lock_phase_e      phase;
        logic [SEL_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_WAIT: begin
                if (key_new) begin
                    if (!match)                  seq_d.phase = PH_ERR;
                    else if (seq_q.idx == LAST_IDX) seq_d.phase = PH_OPEN;
                    else                         seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: ; // error and open are terminal until reset
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase <= PH_WAIT;
            seq_q.idx   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sel    = seq_q.idx;
    assign unlock = (seq_q.phase == PH_OPEN);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && !key_new) |=> (seq_q.phase == PH_WAIT && $stable(seq_q.idx)));

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && key_new && match && seq_q.idx != LAST_IDX)
        |=> (seq_q.phase == PH_WAIT && seq_q.idx == $past(seq_q.idx) + 1'b1));

    // R4
    wrong_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && key_new && !match) |=> (seq_q.phase == PH_ERR && !unlock));

    // R5
    last_match_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_WAIT && key_new && match && seq_q.idx == LAST_IDX) |=> unlock);

    // R6
    open_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_OPEN) |=> (seq_q.phase == PH_OPEN));

    // R7
    err_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.phase == PH_ERR) |=> (seq_q.phase == PH_ERR && !unlock));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (seq_q.phase == PH_WAIT && seq_q.idx == '0 && !unlock));

endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 3,
    parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEFAULT_CODE = 12'h243,
    localparam int CODE_W    = NUM_DIGITS * DIGIT_W,
    localparam int SEL_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIGIT_W-1:0] key_val,
    input  logic              key_new,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              unlock
);

    logic [SEL_W-1:0] sel;
    logic             match;

    lock_code_store #(
        .DIGIT_W      (DIGIT_W),
        .NUM_DIGITS   (NUM_DIGITS),
        .DEFAULT_CODE (DEFAULT_CODE)
    ) i_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_code (cfg_code),
        .sel      (sel),
        .key_val  (key_val),
        .match    (match)
    );

    lock_sequencer #(
        .NUM_DIGITS (NUM_DIGITS)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .key_new (key_new),
        .match   (match),
        .sel     (sel),
        .unlock  (unlock)
    );

endmodule

// File: tb/test_combo_lock.sv
`timescale 1ns/1ps
module test_combo_lock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  key_val = '0;
    logic        key_new = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_code = '0;
    logic        unlock;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    combo_lock i_combo_lock (
        .clk      (clk),
        .rst      (rst),
        .key_val  (key_val),
        .key_new  (key_new),
        .cfg_we   (cfg_we),
        .cfg_code (cfg_code),
        .unlock   (unlock)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: unlock actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] dig(input logic [11:0] code, input int p);
        return code[p*4 +: 4];
    endfunction

    // reset; when we=1 the given code is loaded
    task automatic do_reset(input logic we, input logic [11:0] code);
        @(negedge clk);
        rst = 1'b1; cfg_we = we; cfg_code = code; key_new = 1'b0;
        @(negedge clk);
        rst = 1'b0; cfg_we = 1'b0; cfg_code = ~code;
        chk("R1", unlock, 1'b0);
    endtask

    // gap idle cycles, then one strobed entry; returns after the edge
    task automatic enter(input logic [3:0] v, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            key_new = 1'b0; key_val = ~v;
        end
        @(negedge clk);
        key_val = v; key_new = 1'b1;
        @(negedge clk);
        key_new = 1'b0;
    endtask

    task automatic sweep(input logic we, input logic [11:0] code);
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 16; v++) begin
                logic good;
                good = (4'(v) == dig(code, p));
                do_reset(we, code);
                for (int k = 0; k < 3; k++) begin
                    logic [3:0] e;
                    e = (k == p) ? 4'(v) : dig(code, k);
                    enter(e, (v + k) % 3);
                    if (k < 2) chk("R3/R2", unlock, 1'b0);
                end
                // R9 R5 open only if every entry matched; R4 otherwise
                chk(good ? "R5" : "R4", unlock, good);
                if (!good) begin
                    // R7 restart-on-error would open here
                    for (int k = 0; k < 3; k++) enter(dig(code, k), 0);
                    chk("R7", unlock, 1'b0);
                end
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: unlock actual %b expected finish", unlock);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8 default combination 3,4,2
        sweep(1'b0, 12'h243);
        // R8 loaded combination 9,A,5 and repeated digits 7,7,7
        sweep(1'b1, 12'h5A9);
        sweep(1'b1, 12'h777);

        // R6 open persists under wrong strobes, then reset out of open (R1)
        do_reset(1'b0, 12'h000);
        enter(4'd3, 2); enter(4'd4, 0); enter(4'd2, 4);
        chk("R5", unlock, 1'b1);
        for (int j = 0; j < 16; j++) enter(4'(j), j % 2);
        chk("R6", unlock, 1'b1);
        do_reset(1'b0, 12'h000);
        chk("R1", unlock, 1'b0);
        enter(4'd3, 0); enter(4'd4, 0); enter(4'd2, 0);
        chk("R1", unlock, 1'b1);

        // R2 long idle between entries
        do_reset(1'b0, 12'h000);
        enter(4'd3, 20);
        chk("R2", unlock, 1'b0);
        enter(4'd4, 30);
        enter(4'd2, 25);
        chk("R2", unlock, 1'b1);

        // R7 reset out of error state
        do_reset(1'b0, 12'h000);
        enter(4'd3, 0); enter(4'd9, 0);
        enter(4'd2, 0);
        chk("R7", unlock, 1'b0);
        do_reset(1'b0, 12'h000);
        enter(4'd3, 0); enter(4'd4, 0); enter(4'd2, 0);
        chk("R7", unlock, 1'b1);

        // R8 cfg_we outside reset is ignored
        do_reset(1'b1, 12'h1E6);
        @(negedge clk); cfg_we = 1'b1; cfg_code = 12'h243;
        @(negedge clk); cfg_we = 1'b0;
        enter(4'd6, 0); enter(4'hE, 0); enter(4'd1, 0);
        chk("R8", unlock, 1'b1);
        // R8 reset without load restores the default
        do_reset(1'b0, 12'h1E6);
        enter(4'd3, 0); enter(4'd4, 0); enter(4'd2, 0);
        chk("R8", unlock, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule